// File: doc/BRIEF.md
# Command Bus Decoder with Per-Bank State Tracking

This block watches a double-data-rate memory command/address bus that carries one command per clock. Each cycle it classifies the command on the bus, works out which bank the command addresses, and keeps a record of every bank: whether a row is open, which row it is, and whether a data burst still occupies the bank. Any command that breaks the protocol raises an error pulse. Examples are an unused encoding, opening a bank that is already open, or a column access to a bank that is closed or still busy. A command that breaks the protocol leaves the tracked state as it was.

The row-open command has a strobe of its own. While that strobe is low, the three classic command lines act as the top three row address bits. The bank index has three parts: the stacked-die chip ID, two bank-group bits and two bank bits. This gives 128 tracked banks by default. Address bit 10 selects between command variants. Bit 12 requests a shortened burst, but the bank stays busy for the full burst time.

Each bank runs a three-state machine. The states are CLOSED, OPEN and BURST. The transitions are:
- activate moves CLOSED to OPEN.
- read or write moves OPEN to BURST.
- precharge moves OPEN to CLOSED.
- when the burst ends, BURST moves to CLOSED if a close is pending, and to OPEN otherwise.

Top module: `cmdbus_bank_monitor`

## Requirements
- R1: With chip select (`cs_n`) high, the reported type is 0 (deselect) and the bank field is 0. No bank changes and no error is raised, whatever the other lines carry. With the strobe high and ras/cas/we all high, the type is also 0.
- R2: `cs_n` low with `act_n` low is an activate, type 1. The bank index is {cid,bg,ba}. The row is {ras_n,cas_n,we_n,addr}, with ras_n as the MSB. A closed bank becomes open and holds that row.
- R3: With `act_n` high, ras/cas/we = H,L,H is a read (type 2) and H,L,L is a write (type 3). For both, `addr[10]` is reported as auto-precharge and `addr[12]` as burst chop.
- R4: ras/cas/we = L,H,L is a precharge. With `addr[10]` low (type 4) it closes the addressed bank. With `addr[10]` high (type 5) it closes all 16 banks of the addressed die, ignores bg/ba, and reports bank {cid,0}. A precharge to a closed bank is harmless.
- R5: L,L,H is a refresh (type 6). H,H,L is a ZQ calibration: long when `addr[10]` is high (type 7), short otherwise (type 8). L,L,L is a mode register set (type 9) with bank field {cid,bg,ba}. None of these changes any bank.
- R6: L,H,H with the strobe high is unused. It reports type 10 and raises `proto_err`.
- R7: An activate to a bank that is open or busy raises `proto_err`. The bank keeps its row.
- R8: A read or write to a closed bank raises `proto_err` and changes nothing.
- R9: A legal read or write makes the bank busy for BURST_CLKS-1 cycles. This holds with or without burst chop. A read or write to that bank in that window raises `proto_err`. One issued BURST_CLKS clocks after the first is accepted. Other banks are unaffected.
- R10: An auto-precharge access closes the bank in the cycle its busy flag drops. A precharge to a busy bank is deferred to that same cycle.
- R11: After reset all banks are closed and not busy, all rows are 0, the type is 0 and `proto_err` is low.
- R12: The decoded fields and `proto_err` appear one clock after the command is sampled. They hold for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| act_n | input | 1 | Activate strobe, active low |
| ras_n | input | 1 | Command line / row bit 17 |
| cas_n | input | 1 | Command line / row bit 16 |
| we_n | input | 1 | Command line / row bit 15 |
| addr | input | ADDR_W | Address field (bit 10 variant, bit 12 chop) |
| bg | input | BG_W | Bank group |
| ba | input | BA_W | Bank within group |
| cid | input | CID_W | Stacked-die chip ID |
| cmd_type | output | 4 | Decoded command code |
| cmd_bank | output | CID_W+BG_W+BA_W | Addressed bank index |
| cmd_chop | output | 1 | Burst chop requested |
| cmd_autopre | output | 1 | Auto-precharge requested |
| bank_open | output | NBANK | Per-bank row-open flag |
| bank_busy | output | NBANK | Per-bank burst-busy flag |
| bank_row | output | NBANK x ROW_W | Per-bank open row |
| proto_err | output | 1 | Protocol violation pulse |

## Verification
The bench builds the block with its default parameters: three chip-ID bits (128 banks), a 15-bit address field (18-bit rows) and a four-clock burst. With these values, an all-ones row in the top bank, die-wide precharge leaving a neighbouring die untouched, and back-to-back accesses at the exact edge of the busy window can all be reached. A behavioural model in the bench recomputes every output on every clock. It is driven by directed sequences for each requirement and then by a long random command stream over a small set of banks.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_ACT   = 4'd1,
        CMD_RD    = 4'd2,
        CMD_WR    = 4'd3,
        CMD_PRE   = 4'd4,
        CMD_PREA  = 4'd5,
        CMD_REF   = 4'd6,
        CMD_ZQL   = 4'd7,
        CMD_ZQS   = 4'd8,
        CMD_MRS   = 4'd9,
        CMD_BAD   = 4'd10
    } cmd_e;

    typedef enum logic [1:0] {
        BK_CLOSED = 2'd0,
        BK_OPEN   = 2'd1,
        BK_BURST  = 2'd2
    } bank_st_e;
endpackage

// File: rtl/cbm_decode.sv
module cbm_decode
    import cbm_pkg::*;
(
    input  logic cs_n,
    input  logic act_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic var_bit,
    input  logic chop_bit,
    output cmd_e cmd,
    output logic chop,
    output logic ap
);
    always_comb begin
        cmd  = CMD_DESEL;
        chop = 1'b0;
        ap   = 1'b0;
        if (!cs_n) begin
            if (!act_n) begin
                cmd = CMD_ACT;
            end else begin
                unique case ({ras_n, cas_n, we_n})
                    3'b101: begin cmd = CMD_RD; chop = chop_bit; ap = var_bit; end
                    3'b100: begin cmd = CMD_WR; chop = chop_bit; ap = var_bit; end
                    3'b010: cmd = var_bit ? CMD_PREA : CMD_PRE;
                    3'b001: cmd = CMD_REF;
                    3'b110: cmd = var_bit ? CMD_ZQL : CMD_ZQS;
                    3'b000: cmd = CMD_MRS;
                    3'b011: cmd = CMD_BAD;
                    3'b111: cmd = CMD_DESEL;
                    default: cmd = CMD_BAD;
                endcase
            end
        end
    end
endmodule

// File: rtl/cbm_bank_fsm.sv
module cbm_bank_fsm
    import cbm_pkg::*;
#(
    parameter int ROW_W      = 18,
    parameter int BURST_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_act,
    input  logic             do_rw,
    input  logic             do_pre,
    input  logic             ap,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic             is_busy,
    output logic [ROW_W-1:0] row_q
);
    localparam int CNT_W = (BURST_CLKS > 2) ? $clog2(BURST_CLKS) : 1;

    bank_st_e          st, st_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic              pend, pend_n;
    logic [ROW_W-1:0]  row_n;

    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        pend_n = pend;
        row_n  = row_q;
        unique case (st)
            BK_CLOSED: begin
                if (do_act) begin
                    st_n  = BK_OPEN;
                    row_n = row_in;
                end
            end
            BK_OPEN: begin
                if (do_rw) begin
                    st_n   = BK_BURST;
                    cnt_n  = CNT_W'(BURST_CLKS - 2);
                    pend_n = ap;
                end else if (do_pre) begin
                    st_n = BK_CLOSED;
                end
            end
            BK_BURST: begin
                if (cnt == '0) begin
                    st_n   = (pend || do_pre) ? BK_CLOSED : BK_OPEN;
                    pend_n = 1'b0;
                end else begin
                    cnt_n = cnt - 1'b1;
                    if (do_pre) pend_n = 1'b1;
                end
            end
            default: st_n = BK_CLOSED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= BK_CLOSED;
            cnt   <= '0;
            pend  <= 1'b0;
            row_q <= '0;
        end else begin
            st    <= st_n;
            cnt   <= cnt_n;
            pend  <= pend_n;
            row_q <= row_n;
        end
    end

    assign is_open = (st != BK_CLOSED);
    assign is_busy = (st == BK_BURST);

    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_BURST && cnt != '0) |=> is_busy);

    a_r10_close_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_BURST && cnt == '0 && (pend || do_pre)) |=> (!is_open && !is_busy));
endmodule

// File: rtl/cmdbus_bank_monitor.sv
module cmdbus_bank_monitor
    import cbm_pkg::*;
#(
    parameter int CID_W      = 3,
    parameter int BG_W       = 2,
    parameter int BA_W       = 2,
    parameter int ADDR_W     = 15,
    parameter int BURST_CLKS = 4,
    localparam int IDX_W     = CID_W + BG_W + BA_W,
    localparam int NBANK     = 1 << IDX_W,
    localparam int ROW_W     = ADDR_W + 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        act_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [BG_W-1:0]             bg,
    input  logic [BA_W-1:0]             ba,
    input  logic [CID_W-1:0]            cid,
    output logic [3:0]                  cmd_type,
    output logic [IDX_W-1:0]            cmd_bank,
    output logic                        cmd_chop,
    output logic                        cmd_autopre,
    output logic [NBANK-1:0]            bank_open,
    output logic [NBANK-1:0]            bank_busy,
    output logic [NBANK-1:0][ROW_W-1:0] bank_row,
    output logic                        proto_err
);
    localparam int DIE_SH = BG_W + BA_W;

    initial begin
        a_params_ok: assert (ADDR_W >= 13 && BURST_CLKS >= 2);
    end

    cmd_e             dec;
    logic             dec_chop, dec_ap;
    logic [IDX_W-1:0] idx;
    logic [ROW_W-1:0] row_in;
    logic             is_rw, rw_ok, act_ok, err_d;
    logic [IDX_W-1:0] bank_d;

    assign idx    = {cid, bg, ba};
    assign row_in = {ras_n, cas_n, we_n, addr};

    cbm_decode u_dec (
        .cs_n    (cs_n),
        .act_n   (act_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .var_bit (addr[10]),
        .chop_bit(addr[12]),
        .cmd     (dec),
        .chop    (dec_chop),
        .ap      (dec_ap)
    );

    always_comb begin
        is_rw  = (dec == CMD_RD) || (dec == CMD_WR);
        act_ok = (dec == CMD_ACT) && !bank_open[idx];
        rw_ok  = is_rw && bank_open[idx] && !bank_busy[idx];
        err_d  = (dec == CMD_BAD) || ((dec == CMD_ACT) && !act_ok) || (is_rw && !rw_ok);
        unique case (dec)
            CMD_DESEL: bank_d = '0;
            CMD_PREA:  bank_d = {cid, {DIE_SH{1'b0}}};
            default:   bank_d = idx;
        endcase
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic sel, die_hit, pre_hit;
        assign sel     = (idx == IDX_W'(b));
        assign die_hit = (cid == CID_W'(b >> DIE_SH));
        assign pre_hit = ((dec == CMD_PRE) && sel) || ((dec == CMD_PREA) && die_hit);

        cbm_bank_fsm #(
            .ROW_W     (ROW_W),
            .BURST_CLKS(BURST_CLKS)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .do_act (act_ok && sel),
            .do_rw  (rw_ok && sel),
            .do_pre (pre_hit),
            .ap     (dec_ap),
            .row_in (row_in),
            .is_open(bank_open[b]),
            .is_busy(bank_busy[b]),
            .row_q  (bank_row[b])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_type    <= CMD_DESEL;
            cmd_bank    <= '0;
            cmd_chop    <= 1'b0;
            cmd_autopre <= 1'b0;
            proto_err   <= 1'b0;
        end else begin
            cmd_type    <= dec;
            cmd_bank    <= bank_d;
            cmd_chop    <= dec_chop;
            cmd_autopre <= dec_ap;
            proto_err   <= err_d;
        end
    end

    a_r1_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && bank_busy == '0) |=> ($stable(bank_open) && !proto_err && cmd_type == 4'd0));

    a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !act_n && !bank_open[idx]) |=> (bank_open[cmd_bank] && !proto_err));

    a_r6_unused_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && act_n && !ras_n && cas_n && we_n) |=> proto_err);

    a_r7_act_on_open: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !act_n && bank_open[idx]) |=> proto_err);

    a_r8_rw_on_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && act_n && ras_n && !cas_n && !bank_open[idx]) |=> (proto_err && !bank_busy[cmd_bank]));
endmodule

// File: tb/cmdbus_bank_monitor_test.sv
module cmdbus_bank_monitor_test;
    localparam int NB = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, act_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [14:0] addr = '0;
    logic [1:0] bg = '0, ba = '0;
    logic [2:0] cid = '0;
    logic [3:0] cmd_type;
    logic [6:0] cmd_bank;
    logic cmd_chop, cmd_autopre, proto_err;
    logic [NB-1:0] bank_open, bank_busy;
    logic [NB-1:0][17:0] bank_row;

    cmdbus_bank_monitor uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .act_n(act_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .bg(bg), .ba(ba), .cid(cid),
        .cmd_type(cmd_type), .cmd_bank(cmd_bank), .cmd_chop(cmd_chop),
        .cmd_autopre(cmd_autopre), .bank_open(bank_open), .bank_busy(bank_busy),
        .bank_row(bank_row), .proto_err(proto_err)
    );

    always #2 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R11";
    bit done = 0;

    bit m_open[NB];
    int m_row[NB];
    int m_bl[NB];
    bit m_pend[NB];
    int e_type = 0, e_bank = 0;
    bit e_chop = 0, e_ap = 0, e_err = 0;

    // reference model: one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin
                m_open[i] = 0; m_row[i] = 0; m_bl[i] = 0; m_pend[i] = 0;
            end
            e_type = 0; e_bank = 0; e_chop = 0; e_ap = 0; e_err = 0;
        end else begin
            int t, b, rw;
            bit a10, a12;
            b = {cid, bg, ba};
            a10 = addr[10]; a12 = addr[12];
            if (cs_n) t = 0;
            else if (!act_n) t = 1;
            else begin
                case ({ras_n, cas_n, we_n})
                    3'b101: t = 2;
                    3'b100: t = 3;
                    3'b010: t = a10 ? 5 : 4;
                    3'b001: t = 6;
                    3'b110: t = a10 ? 7 : 8;
                    3'b000: t = 9;
                    3'b011: t = 10;
                    default: t = 0;
                endcase
            end
            rw = (t == 2 || t == 3);
            e_type = t;
            e_bank = (t == 0) ? 0 : (t == 5) ? cid * 16 : b;
            e_chop = rw && a12;
            e_ap   = rw && a10;
            e_err  = (t == 10) || (t == 1 && m_open[b]) || (rw && (!m_open[b] || m_bl[b] > 0));
            for (int i = 0; i < NB; i++) begin
                if (m_bl[i] > 0) begin
                    m_bl[i]--;
                    if (m_bl[i] == 0 && m_pend[i]) begin m_open[i] = 0; m_pend[i] = 0; end
                end
            end
            if (!e_err) begin
                if (t == 1) begin m_open[b] = 1; m_row[b] = {ras_n, cas_n, we_n, addr}; end
                if (rw) begin m_bl[b] = 3; m_pend[b] = a10; end
                if (t == 4) begin
                    if (m_bl[b] > 0) m_pend[b] = 1; else m_open[b] = 0;
                end
                if (t == 5) begin
                    for (int i = cid * 16; i < cid * 16 + 16; i++) begin
                        if (m_bl[i] > 0) m_pend[i] = 1; else m_open[i] = 0;
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NB-1:0] eo, eb;
            int rbad;
            chk(cmd_type == 4'(e_type), "cmd_type", cmd_type, e_type);
            chk(cmd_bank == 7'(e_bank), "cmd_bank", cmd_bank, e_bank);
            chk(cmd_chop == e_chop && cmd_autopre == e_ap, "chop/autopre",
                {cmd_chop, cmd_autopre}, {e_chop, e_ap});
            chk(proto_err == e_err, "proto_err", proto_err, e_err);
            rbad = -1;
            for (int i = 0; i < NB; i++) begin
                eo[i] = m_open[i];
                eb[i] = (m_bl[i] > 0);
                if (bank_row[i] != 18'(m_row[i]) && rbad < 0) rbad = i;
            end
            for (int q = 0; q < 2; q++) begin
                chk(bank_open[q*64 +: 64] == eo[q*64 +: 64], "bank_open", bank_open[q*64 +: 64], eo[q*64 +: 64]);
                chk(bank_busy[q*64 +: 64] == eb[q*64 +: 64], "bank_busy", bank_busy[q*64 +: 64], eb[q*64 +: 64]);
            end
            chk(rbad < 0, "bank_row", (rbad < 0) ? 0 : bank_row[rbad], (rbad < 0) ? 0 : m_row[rbad]);
        end
    end

    task automatic put(input bit c, input bit a, input bit r, input bit ca, input bit w,
                       input int ad, input int bk);
        @(negedge clk);
        cs_n = c; act_n = a; ras_n = r; cas_n = ca; we_n = w;
        addr = 15'(ad); cid = 3'(bk >> 4); bg = 2'(bk >> 2); ba = 2'(bk);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1, 1, 1, 1, 1, 0, 0);
    endtask
    task automatic act(input int bk, input int row);
        put(0, 0, row[17], row[16], row[15], row & 32'h7fff, bk);
    endtask
    task automatic rd(input int bk, input bit ap, input bit bc);
        put(0, 1, 1, 0, 1, (ap << 10) | (bc << 12), bk);
    endtask
    task automatic wr(input int bk, input bit ap, input bit bc);
        put(0, 1, 1, 0, 0, (ap << 10) | (bc << 12), bk);
    endtask
    task automatic pre(input int bk, input bit all);
        put(0, 1, 0, 1, 0, all << 10, bk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R11";
        rst_n = 1'b1;
        idle(2);
        cur_req = "R1";
        put(1, 0, 0, 0, 0, 15'h7fff, 127);
        put(1, 1, 0, 1, 1, 15'h1400, 5);
        put(0, 1, 1, 1, 1, 15'h0400, 9);
        idle(1);
        cur_req = "R2";
        act(5, 18'h2ABCD);
        act(127, 18'h3FFFF);
        act(0, 0);
        idle(1);
        cur_req = "R7";
        act(5, 18'h00011);
        idle(1);
        cur_req = "R3";
        rd(5, 0, 1);
        idle(3);
        wr(127, 0, 0);
        idle(3);
        cur_req = "R9";
        rd(5, 0, 0);
        rd(5, 0, 0);
        wr(127, 0, 1);
        wr(5, 0, 0);
        rd(5, 0, 0);
        idle(4);
        cur_req = "R8";
        rd(9, 0, 0);
        wr(100, 1, 1);
        idle(1);
        cur_req = "R10";
        wr(5, 1, 0);
        idle(4);
        rd(127, 0, 0);
        pre(127, 0);
        act(127, 5);
        idle(4);
        cur_req = "R4";
        act(32, 18'h111); act(40, 18'h222); act(47, 18'h333); act(48, 18'h444);
        rd(40, 0, 0);
        pre(33, 1);
        idle(4);
        pre(0, 0);
        pre(0, 0);
        idle(1);
        cur_req = "R5";
        put(0, 1, 0, 0, 1, 0, 48);
        put(0, 1, 1, 1, 0, 15'h0400, 3);
        put(0, 1, 1, 1, 0, 0, 3);
        put(0, 1, 0, 0, 0, 15'h1234, 6);
        idle(1);
        cur_req = "R6";
        put(0, 1, 0, 1, 1, 0, 48);
        idle(1);
        cur_req = "R12";
        for (int i = 0; i < 600; i++) begin
            int k, bk;
            k = $urandom_range(0, 15);
            bk = (k & 3) | ((k & 4) << 2) | ((k & 8) << 3);
            case ($urandom_range(0, 7))
                0: act(bk, $urandom_range(0, 262143));
                1, 2: rd(bk, $urandom_range(0, 3) == 0, $urandom_range(0, 1));
                3: wr(bk, $urandom_range(0, 3) == 0, $urandom_range(0, 1));
                4: pre(bk, $urandom_range(0, 5) == 0);
                5: put($urandom_range(0, 1), 1, $urandom_range(0, 1), $urandom_range(0, 1),
                       $urandom_range(0, 1), $urandom_range(0, 32767), bk);
                default: idle(1);
            endcase
        end
        idle(6);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule